// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is a parallel-in, serial-out shift register that runs inside a synchronous design. A free-running system clock samples every external input: two slow clock lines, an active-low load control, a serial data bit and a parallel data word. After synchronisation the two clock lines are ORed into one effective clock, so either line held high stops shifting. Each rising edge of that effective clock moves the word one stage toward the last stage, and the serial bit enters the first stage. The last stage is driven out in true and in inverted form.

While the load control is low, the register follows the parallel word continuously, and clocks and the serial bit have no effect. The inhibit line may only rise while the clock line is already high. A rise of the inhibit line while the clock line is low would form a false edge, so the block records it in a sticky flag.

Top module: `par_serial_shreg`

## Requirements
- R1: While `rst_n` is low, all stages clear to zero, `q_out` is 0, `q_out_n` is 1 and `inh_violation` is 0. This state holds once reset is released until an input changes it.
- R2: While `shift_ld_n` is low, the stages copy `par_in` on every system clock. `clk_in`, `clk_inh` and `ser_in` have no effect during that time. Stage A is `par_in[0]` and stage H is `par_in[7]`.
- R3: While `shift_ld_n` is high, each rising edge of the effective clock (`clk_in | clk_inh`) shifts the stages one place from A toward H. `ser_in` enters stage A. Falling edges do not shift.
- R4: While one clock line is held high, toggling the other line causes no shift.
- R5: If a load and an effective-clock rising edge reach the register in the same cycle, the load wins and the stages take `par_in` without shifting.
- R6: `q_out_n` is always the inverse of `q_out`, and `q_out` is stage H.
- R7: A rise of `clk_inh` while `clk_in` is low sets `inh_violation`. The flag stays set until reset.
- R8: A change on any input shows at the outputs exactly three system clock cycles after it is sampled: two synchroniser stages and one register stage. It is not visible after two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_in | input | 1 | External shift clock line |
| clk_inh | input | 1 | External clock inhibit line |
| shift_ld_n | input | 1 | High: shift; low: load the parallel word |
| ser_in | input | 1 | Serial data into stage A |
| par_in | input | 8 | Parallel data, bit 0 to stage A, bit 7 to stage H |
| q_out | output | 1 | Stage H |
| q_out_n | output | 1 | Stage H inverted |
| inh_violation | output | 1 | Sticky flag for an illegal rise of the inhibit line |

## Verification
The assertions assume that each external line stays at one level for at least several system clock cycles. This lets the synchronised copies of the data, load and clock lines change together. The stimulus changes every input on one falling system edge and then holds it for three full cycles. The inhibit line is raised only while `clk_in` is high, except in the one directed case that exercises the violation flag. The shift data is always set up in the same cycle as the clock rise it goes with, so the effective edge finds the new serial bit in the synchronised set.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned PSR_WIDTH       = 8;
  localparam int unsigned PSR_SYNC_STAGES = 2;

  typedef struct packed {
    logic clk_line;
    logic inh_line;
    logic ld_n;
    logic ser;
  } psr_ctl_t;
endpackage

// File: rtl/psr_rst_sync.sv
module psr_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] rst_pipe_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe_q <= 2'b00;
    else          rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_n_o = rst_pipe_q[1];
endmodule

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/psr_clk_gate.sv
module psr_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_s,
  input  logic inh_s,
  output logic shift_edge,
  output logic viol
);
  logic eff_d, eff_q;
  logic inh_q;
  logic viol_d, viol_q;

  always_comb begin
    eff_d      = clk_s | inh_s;
    shift_edge = eff_d & ~eff_q;
    viol_d     = viol_q | (inh_s & ~inh_q & ~clk_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q  <= 1'b0;
      inh_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      eff_q  <= eff_d;
      inh_q  <= inh_s;
      viol_q <= viol_d;
    end
  end

  assign viol = viol_q;

  p_inh_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_s && $past(inh_s)) |-> !shift_edge);
  p_clk_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_s && $past(clk_s)) |-> !shift_edge);
  p_flag_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_s && !$past(inh_s) && !clk_s) |=> viol);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol);
endmodule

// File: rtl/psr_shift_core.sv
module psr_shift_core #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_n,
  input  logic             ser,
  input  logic [WIDTH-1:0] par,
  input  logic             shift_edge,
  output logic [WIDTH-1:0] stages
);
  logic [WIDTH-1:0] stages_d, stages_q;
  logic             stages_en;

  always_comb begin
    stages_en = ~ld_n | shift_edge;
    if (!ld_n) stages_d = par;
    else       stages_d = {stages_q[WIDTH-2:0], ser};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stages_q <= '0;
    else if (stages_en) stages_q <= stages_d;
  end

  assign stages = stages_q;

  p_load_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> (stages == $past(par)));
  p_shift_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n && shift_edge) |=> (stages == {$past(stages[WIDTH-2:0]), $past(ser)}));
  p_hold_no_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n && !shift_edge) |=> $stable(stages));
  p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && shift_edge) |=> (stages == $past(par)));
endmodule

// File: rtl/par_serial_shreg.sv
module par_serial_shreg
  import psr_pkg::*;
#(
  parameter int unsigned WIDTH       = PSR_WIDTH,
  parameter int unsigned SYNC_STAGES = PSR_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_in,
  input  logic             clk_inh,
  input  logic             shift_ld_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             q_out,
  output logic             q_out_n,
  output logic             inh_violation
);
  localparam int unsigned CTL_W = $bits(psr_ctl_t);
  localparam int unsigned ALL_W = CTL_W + WIDTH;

  logic             rst_sync_n;
  psr_ctl_t         ctl_raw, ctl_s;
  logic [WIDTH-1:0] par_s;
  logic [ALL_W-1:0] sync_d, sync_q;
  logic             shift_edge;
  logic [WIDTH-1:0] stages;

  psr_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  always_comb begin
    ctl_raw.clk_line = clk_in;
    ctl_raw.inh_line = clk_inh;
    ctl_raw.ld_n     = shift_ld_n;
    ctl_raw.ser      = ser_in;
    sync_d           = {ctl_raw, par_in};
  end

  psr_sync #(.WIDTH(ALL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (sync_d),
    .q     (sync_q)
  );

  assign ctl_s = sync_q[ALL_W-1:WIDTH];
  assign par_s = sync_q[WIDTH-1:0];

  psr_clk_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clk_s      (ctl_s.clk_line),
    .inh_s      (ctl_s.inh_line),
    .shift_edge (shift_edge),
    .viol       (inh_violation)
  );

  psr_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ld_n       (ctl_s.ld_n),
    .ser        (ctl_s.ser),
    .par        (par_s),
    .shift_edge (shift_edge),
    .stages     (stages)
  );

  assign q_out   = stages[WIDTH-1];
  assign q_out_n = ~stages[WIDTH-1];
endmodule

// File: tb/par_serial_shreg_tb_top.sv
module par_serial_shreg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clk_in, clk_inh, shift_ld_n, ser_in;
  logic [7:0] par_in;
  logic       q_out, q_out_n, inh_violation;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] exp_reg = 8'h00;
  logic       exp_viol = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_serial_shreg dut_i (
    .clk(clk), .rst_n(rst_n), .clk_in(clk_in), .clk_inh(clk_inh),
    .shift_ld_n(shift_ld_n), .ser_in(ser_in), .par_in(par_in),
    .q_out(q_out), .q_out_n(q_out_n), .inh_violation(inh_violation)
  );

  function automatic logic [7:0] model_shift(logic [7:0] cur, logic s);
    return {cur[6:0], s};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_outs(string req);
    check(req, {7'd0, q_out}, {7'd0, exp_reg[7]});
    check({req, "/R6"}, {7'd0, q_out_n}, {7'd0, ~exp_reg[7]});
    check({req, "/R7"}, {7'd0, inh_violation}, {7'd0, exp_viol});
  endtask

  task automatic do_load(logic [7:0] v);
    par_in = v; shift_ld_n = 1'b0; tick(3);
    exp_reg = v;
    check_outs("R2 load");
    ser_in = ~ser_in; clk_in = 1'b1; tick(3);
    clk_in = 1'b0; tick(3);
    check_outs("R2 clock ignored in load");
    shift_ld_n = 1'b1; tick(3);
  endtask

  task automatic do_shift(logic s);
    ser_in = s; clk_in = 1'b1; tick(3);
    exp_reg = model_shift(exp_reg, s);
    check_outs("R3 shift");
    clk_in = 1'b0; tick(3);
    check_outs("R3 falling edge no shift");
  endtask

  task automatic do_inhibited(logic s);
    ser_in = s;
    clk_in = 1'b1; tick(3);
    exp_reg = model_shift(exp_reg, s);
    clk_inh = 1'b1; tick(3);
    clk_in = 1'b0; tick(3);
    clk_in = 1'b1; tick(3);
    check_outs("R4 inhibit high blocks clock");
    clk_inh = 1'b0; tick(3);
    clk_inh = 1'b1; tick(3);
    clk_inh = 1'b0; tick(3);
    check_outs("R4 clock high blocks inhibit line");
    clk_in = 1'b0; tick(3);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog timeout");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] orig, got;
    void'($urandom(32'h1655));
    rst_n = 1'b0; clk_in = 1'b0; clk_inh = 1'b0;
    shift_ld_n = 1'b1; ser_in = 1'b0; par_in = 8'h00;
    tick(4);
    rst_n = 1'b1; tick(6);
    check_outs("R1 reset state");

    // R8: exact latency
    par_in = 8'h80; shift_ld_n = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R8 not yet visible", {7'd0, q_out}, 8'h00);
    @(posedge clk); @(negedge clk);
    exp_reg = 8'h80;
    check("R8 visible after three", {7'd0, q_out}, 8'h01);
    shift_ld_n = 1'b1; tick(3);

    // R3: full byte out, serial fed back
    do_load(8'hB4);
    orig = 8'hB4; got = 8'h00;
    for (int i = 0; i < 8; i++) begin
      got[7-i] = q_out;
      do_shift(q_out);
    end
    check("R3 byte out msb first", got, orig);

    // R5: load and clock rise together
    do_load(8'h3C);
    par_in = 8'hC3; shift_ld_n = 1'b0; clk_in = 1'b1; ser_in = 1'b1; tick(3);
    exp_reg = 8'hC3;
    check_outs("R5 load wins");
    shift_ld_n = 1'b1; tick(3);
    check_outs("R5 no late shift");
    clk_in = 1'b0; tick(3);
    for (int i = 0; i < 8; i++) begin
      check("R5 content", {7'd0, q_out}, {7'd0, exp_reg[7]});
      do_shift(1'b0);
    end

    do_inhibited(1'b1);

    // random mix
    for (int i = 0; i < 150; i++) begin
      case ($urandom_range(0, 3))
        0:       do_load(8'($urandom));
        1, 2:    do_shift(1'($urandom));
        default: do_inhibited(1'($urandom));
      endcase
    end

    // R7: illegal inhibit rise while clock low (also an effective edge)
    ser_in = 1'b1; clk_inh = 1'b1; tick(3);
    exp_reg = model_shift(exp_reg, 1'b1);
    exp_viol = 1'b1;
    check_outs("R7 violation flagged");
    clk_inh = 1'b0; tick(3);
    check_outs("R7 flag sticky");

    // R1: reset again clears everything
    rst_n = 1'b0; tick(2);
    exp_reg = 8'h00; exp_viol = 1'b0;
    check_outs("R1 reset asserted");
    rst_n = 1'b1; tick(6);
    check_outs("R1 reset released");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule